// File: doc/BRIEF.md
# Single-Cycle Sixteen-Bit Register Processor

This block is a small processor core that completes one instruction on every rising clock edge. Instructions and data sit in two separate word-addressed memories inside the block. Each 16-bit instruction reads up to two of eight 16-bit registers. The operands pass through a function unit and a one-bit shifter, and the result or a data-memory word is written back, all in the same cycle. Branches test the A-source register, and a jump loads the program counter from it.

The instruction word is decoded by a few gates, because the operation code was assigned with that decoder in mind. The top bits of the operation code pick the instruction class. The low four bits pick the function unit operation directly. Memory depth is set by the parameter `AW`: the architecture allows up to 15 address bits, and the default is 8 so that the model stays small.

While reset is held, a write-only load port fills either memory one word per cycle. Reset releases execution from address 0. Observation pins show the program counter, the register write-back and the data-memory write of the instruction now in progress.

Top module: `sc_core`

## Requirements
- R1: The instruction holds the operation code in bits 15:9, the destination register in bits 8:6, source A in bits 5:3 and source B in bits 2:0. The register-format operations, with their codes, are: pass A 0000000, A+1 0000001, A+B 0000010, A-B 0000101, A-1 0000110, A AND B 0001000, A OR B 0001001, A XOR B 0001010, NOT A 0001011 and pass B 0001100. Each writes its 16-bit result to the destination register.
- R2: Shift right (0001101) and shift left (0001110) move the source-B register by one bit, insert 0 in the vacated bit, and write the destination register.
- R3: In the immediate format, bits 2:0 are zero-extended to a constant from 0 to 7. Code 1001100 writes the constant, and 1000010 writes source A plus the constant.
- R4: Load (0010000) writes the data-memory word at address R[SA] into the destination register in the same cycle.
- R5: Store (0100000) writes R[SB] to data memory at address R[SA] on the clock edge. dm_we_o, dm_addr_o and dm_wdata_o show the write during its cycle.
- R6: Code 1100000 branches when R[SA] is zero, and code 1100001 branches when bit 15 of R[SA] is set. A taken branch sets PC to PC plus the sign-extended 6-bit offset {bits 8:6, bits 2:0}, modulo 2^AW. Any other instruction that is not a jump, including a branch that is not taken, sets PC to PC+1.
- R7: An instruction whose bits 15:13 are 111 is a jump and loads PC with the low AW bits of R[SA].
- R8: A synchronous reset sets PC to 0 on the next rising edge. While reset is high, rf_we_o and dm_we_o stay low.
- R9: load_ready equals rst. A word is written only when load_valid and load_ready are both high at a rising edge: to instruction memory when load_sel is 0 and to data memory when load_sel is 1. A load attempted while running changes nothing.
- R10: Store, branch and jump instructions never write a register (rf_we_o low), and only store raises dm_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| load_valid | input | 1 | Load port word valid |
| load_ready | output | 1 | Load port accepts a word (high during reset) |
| load_sel | input | 1 | 0 selects instruction memory, 1 selects data memory |
| load_addr | input | AW | Load port word address |
| load_data | input | 16 | Load port word |
| pc_o | output | AW | Address of the instruction now executing |
| rf_we_o | output | 1 | Register write at the coming edge |
| rf_waddr_o | output | 3 | Destination register of that write |
| rf_wdata_o | output | 16 | Value being written back |
| dm_we_o | output | 1 | Data-memory store at the coming edge |
| dm_addr_o | output | AW | Store address |
| dm_wdata_o | output | 16 | Store data |

## Verification
A corrupted program counter shows up on pc_o in the very next cycle, and every later instruction from then on differs. A wrong register value stays hidden until an instruction reads that register. It then shows on rf_wdata_o, dm_wdata_o or a branch decision in that cycle. The bench therefore reads each result back through later operations and branches. A lost or misplaced store is invisible until a later load of that address returns the old word. For that reason the program loads address 70 both before and after the store to it.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned IW    = 16;
  localparam int unsigned RIDXW = 3;
  localparam int unsigned NREG  = 1 << RIDXW;
  localparam int unsigned OFFW  = 6;

  typedef enum logic [3:0] {
    FS_PASSA  = 4'h0,
    FS_INC    = 4'h1,
    FS_ADD    = 4'h2,
    FS_ADDINC = 4'h3,
    FS_ADDNB  = 4'h4,
    FS_SUB    = 4'h5,
    FS_DEC    = 4'h6,
    FS_PASSA2 = 4'h7,
    FS_AND    = 4'h8,
    FS_OR     = 4'h9,
    FS_XOR    = 4'hA,
    FS_NOTA   = 4'hB,
    FS_PASSB  = 4'hC,
    FS_SHR    = 4'hD,
    FS_SHL    = 4'hE,
    FS_PASSB2 = 4'hF
  } fsel_e;

  typedef struct packed {
    logic  use_const;  // operand B from zero-extended field
    logic  wb_mem;     // write back data memory word
    logic  reg_wr;
    logic  mem_wr;
    logic  pc_load;    // branch or jump class
    logic  is_jump;
    logic  on_neg;     // branch condition: negative, else zero
    fsel_e fsel;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [IW-1:0]    instr,
  output ctrl_t            ctrl,
  output logic [RIDXW-1:0] dst,
  output logic [RIDXW-1:0] src_a,
  output logic [RIDXW-1:0] src_b,
  output logic [OFFW-1:0]  offset
);
  logic pc_class;

  assign pc_class = instr[15] & instr[14];

  always_comb begin
    ctrl.use_const = instr[15];
    ctrl.wb_mem    = instr[13];
    ctrl.reg_wr    = ~instr[14];
    ctrl.mem_wr    = instr[14] & ~instr[15];
    ctrl.pc_load   = pc_class;
    ctrl.is_jump   = instr[13];
    ctrl.on_neg    = instr[9];
    // branches reuse bit 9 as condition select, so mask it from the function code
    ctrl.fsel      = fsel_e'({instr[12:10], instr[9] & ~pc_class});
  end

  assign dst    = instr[8:6];
  assign src_a  = instr[5:3];
  assign src_b  = instr[2:0];
  assign offset = {instr[8:6], instr[2:0]};
endmodule

// File: rtl/sc_func_unit.sv
module sc_func_unit
  import sc_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  fsel_e         fsel,
  output logic [DW-1:0] res,
  output logic          neg,
  output logic          zero
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    case (fsel)
      FS_PASSA:  res = opa;
      FS_INC:    res = opa + ONE;
      FS_ADD:    res = opa + opb;
      FS_ADDINC: res = opa + opb + ONE;
      FS_ADDNB:  res = opa + ~opb;
      FS_SUB:    res = opa - opb;
      FS_DEC:    res = opa - ONE;
      FS_PASSA2: res = opa;
      FS_AND:    res = opa & opb;
      FS_OR:     res = opa | opb;
      FS_XOR:    res = opa ^ opb;
      FS_NOTA:   res = ~opa;
      FS_PASSB:  res = opb;
      FS_SHR:    res = {1'b0, opb[DW-1:1]};
      FS_SHL:    res = {opb[DW-2:0], 1'b0};
      default:   res = opb;
    endcase
  end

  assign neg  = res[DW-1];
  assign zero = (res == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned DW    = 16,
  parameter int unsigned RIDXW = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [RIDXW-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [RIDXW-1:0] raddr_a,
  input  logic [RIDXW-1:0] raddr_b,
  output logic [DW-1:0]    rdata_a,
  output logic [DW-1:0]    rdata_b
);
  localparam int unsigned NREG = 1 << RIDXW;

  logic [DW-1:0] rd_bus [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (we && (waddr == RIDXW'(g))) q <= wdata;
    end
    assign rd_bus[g] = q;
  end

  assign rdata_a = rd_bus[raddr_a];
  assign rdata_b = rd_bus[raddr_b];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic             load_sel,
  input  logic [AW-1:0]    load_addr,
  input  logic [IW-1:0]    load_data,
  output logic [AW-1:0]    pc_o,
  output logic             rf_we_o,
  output logic [RIDXW-1:0] rf_waddr_o,
  output logic [IW-1:0]    rf_wdata_o,
  output logic             dm_we_o,
  output logic [AW-1:0]    dm_addr_o,
  output logic [IW-1:0]    dm_wdata_o
);
  localparam int unsigned DW = IW;
  localparam logic [AW-1:0] PC_ONE = AW'(1);

  logic [AW-1:0]    pc;
  logic [AW-1:0]    pc_next;
  logic [AW-1:0]    pc_seq;
  logic [AW-1:0]    pc_tgt;
  logic [IW-1:0]    instr;
  ctrl_t            ctrl;
  logic [RIDXW-1:0] dst, src_a, src_b;
  logic [OFFW-1:0]  offset;
  logic [DW-1:0]    rega, regb, opb, fu_res, dm_rdata, wb_data;
  logic             fu_neg, fu_zero, cond;
  logic             load_fire, im_we, dm_we_core, dm_we_any;
  logic [AW-1:0]    dm_waddr;
  logic [DW-1:0]    dm_wdata;

  // load port: open only during reset
  assign load_ready = rst;
  assign load_fire  = load_valid & load_ready;
  assign im_we      = load_fire & ~load_sel;

  sc_mem #(.DW(IW), .AW(AW)) u_imem (
    .clk(clk), .we(im_we), .waddr(load_addr), .wdata(load_data),
    .raddr(pc), .rdata(instr)
  );

  sc_decoder u_dec (
    .instr(instr), .ctrl(ctrl), .dst(dst), .src_a(src_a), .src_b(src_b),
    .offset(offset)
  );

  sc_regfile #(.DW(DW), .RIDXW(RIDXW)) u_rf (
    .clk(clk), .we(rf_we_o), .waddr(dst), .wdata(wb_data),
    .raddr_a(src_a), .raddr_b(src_b), .rdata_a(rega), .rdata_b(regb)
  );

  assign opb = ctrl.use_const ? {{(DW-3){1'b0}}, src_b} : regb;

  sc_func_unit #(.DW(DW)) u_fu (
    .opa(rega), .opb(opb), .fsel(ctrl.fsel),
    .res(fu_res), .neg(fu_neg), .zero(fu_zero)
  );

  // data memory: core store when running, load port during reset
  assign dm_we_core = ctrl.mem_wr & ~rst;
  assign dm_we_any  = dm_we_core | (load_fire & load_sel);
  assign dm_waddr   = rst ? load_addr : rega[AW-1:0];
  assign dm_wdata   = rst ? load_data : regb;

  sc_mem #(.DW(DW), .AW(AW)) u_dmem (
    .clk(clk), .we(dm_we_any), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(rega[AW-1:0]), .rdata(dm_rdata)
  );

  assign wb_data = ctrl.wb_mem ? dm_rdata : fu_res;

  // program counter and branch control
  assign pc_seq = pc + PC_ONE;
  assign pc_tgt = pc + {{(AW-OFFW){offset[OFFW-1]}}, offset};
  assign cond   = ctrl.on_neg ? fu_neg : fu_zero;

  always_comb begin
    if (!ctrl.pc_load)     pc_next = pc_seq;
    else if (ctrl.is_jump) pc_next = rega[AW-1:0];
    else if (cond)         pc_next = pc_tgt;
    else                   pc_next = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign pc_o       = pc;
  assign rf_we_o    = ctrl.reg_wr & ~rst;
  assign rf_waddr_o = dst;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = dm_we_core;
  assign dm_addr_o  = rega[AW-1:0];
  assign dm_wdata_o = regb;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [15:0]   instr,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] jmp_tgt,
  input logic          a_zero,
  input logic          rf_we,
  input logic          dm_we
);
  logic [AW-1:0] off_ext;
  assign off_ext = {{(AW-6){instr[8]}}, instr[8:6], instr[2:0]};

  AST_RESET_PC: assert property (@(posedge clk) rst |=> (pc == '0)); // R8

  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk)
    rst |-> (!rf_we && !dm_we)); // R8

  AST_STORE_EXCL: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we); // R10

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (instr[15:14] != 2'b11) |=> (pc == AW'($past(pc) + AW'(1)))); // R6

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (instr[15:13] == 3'b111) |=> (pc == $past(jmp_tgt))); // R7

  AST_BRZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (instr[15:13] == 3'b110 && !instr[9] && a_zero)
      |=> (pc == AW'($past(pc) + $past(off_ext)))); // R6
endmodule

bind sc_core sc_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .pc(pc), .jmp_tgt(rega[AW-1:0]),
  .a_zero(rega == '0), .rf_we(rf_we_o), .dm_we(dm_we_o)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  localparam logic [6:0] OP_MOVA = 7'h00, OP_INC = 7'h01, OP_ADD = 7'h02,
    OP_SUB = 7'h05, OP_DEC = 7'h06, OP_AND = 7'h08, OP_OR = 7'h09,
    OP_XOR = 7'h0A, OP_NOT = 7'h0B, OP_MOVB = 7'h0C, OP_SHR = 7'h0D,
    OP_SHL = 7'h0E, OP_LDI = 7'h4C, OP_ADI = 7'h42, OP_LD = 7'h10,
    OP_ST = 7'h20, OP_BRZ = 7'h60, OP_BRN = 7'h61, OP_JMP = 7'h70;

  function automatic logic [15:0] enc(input logic [6:0] op, input logic [2:0] d,
                                      input logic [2:0] a, input logic [2:0] b);
    return {op, d, a, b};
  endfunction

  function automatic logic [15:0] br(input logic [6:0] op, input logic [2:0] a,
                                     input logic [5:0] ad);
    return {op, ad[5:3], a, ad[2:0]};
  endfunction

  localparam int NPROG = 34;
  // {address, instruction}
  localparam logic [23:0] PROG [NPROG] = '{
    {8'd0,  enc(OP_LDI, 3'd1, 3'd0, 3'd7)},
    {8'd1,  enc(OP_LDI, 3'd2, 3'd0, 3'd5)},
    {8'd2,  enc(OP_ADD, 3'd3, 3'd1, 3'd2)},
    {8'd3,  enc(OP_SUB, 3'd4, 3'd2, 3'd1)},
    {8'd4,  enc(OP_INC, 3'd5, 3'd3, 3'd0)},
    {8'd5,  enc(OP_DEC, 3'd6, 3'd2, 3'd0)},
    {8'd6,  enc(OP_AND, 3'd7, 3'd1, 3'd2)},
    {8'd7,  enc(OP_OR,  3'd7, 3'd3, 3'd2)},
    {8'd8,  enc(OP_XOR, 3'd7, 3'd3, 3'd1)},
    {8'd9,  enc(OP_NOT, 3'd7, 3'd1, 3'd0)},
    {8'd10, enc(OP_MOVA, 3'd7, 3'd4, 3'd0)},
    {8'd11, enc(OP_MOVB, 3'd7, 3'd0, 3'd3)},
    {8'd12, enc(OP_SHL, 3'd7, 3'd0, 3'd4)},
    {8'd13, enc(OP_SHR, 3'd7, 3'd0, 3'd4)},
    {8'd14, enc(OP_ADI, 3'd5, 3'd5, 3'd3)},
    {8'd15, br(OP_BRN, 3'd4, 6'd2)},
    {8'd16, enc(OP_LDI, 3'd1, 3'd0, 3'd0)},
    {8'd17, br(OP_BRZ, 3'd2, 6'd3)},
    {8'd18, br(OP_BRN, 3'd1, 6'd3)},
    {8'd19, enc(OP_SHL, 3'd6, 3'd0, 3'd5)},
    {8'd20, enc(OP_SHL, 3'd6, 3'd0, 3'd6)},
    {8'd21, enc(OP_ADI, 3'd4, 3'd6, 3'd6)},
    {8'd22, enc(OP_LD,  3'd7, 3'd4, 3'd0)},
    {8'd23, enc(OP_ADD, 3'd5, 3'd6, 3'd5)},
    {8'd24, enc(OP_LDI, 3'd1, 3'd0, 3'd0)},
    {8'd25, br(OP_BRZ, 3'd1, 6'd10)},
    {8'd35, enc(OP_ST,  3'd0, 3'd4, 3'd5)},
    {8'd36, enc(OP_LD,  3'd3, 3'd4, 3'd0)},
    {8'd37, enc(OP_LDI, 3'd6, 3'd0, 3'd0)},
    {8'd38, br(OP_BRZ, 3'd1, 6'd16)},
    {8'd39, enc(OP_JMP, 3'd0, 3'd3, 3'd0)},
    {8'd54, enc(OP_INC, 3'd1, 3'd1, 3'd0)},
    {8'd55, br(OP_BRZ, 3'd6, 6'b101100)},
    {8'd80, br(OP_BRZ, 3'd6, 6'd0)}
  };

  localparam int NTRACE = 38;
  // {pc, rf_we, rf_waddr, rf_wdata, dm_we, requirement number}
  localparam logic [32:0] TRACE [NTRACE] = '{
    {8'd0,  1'b1, 3'd1, 16'h0007, 1'b0, 4'd3},  // R3 LDI
    {8'd1,  1'b1, 3'd2, 16'h0005, 1'b0, 4'd3},  // R3
    {8'd2,  1'b1, 3'd3, 16'h000C, 1'b0, 4'd1},  // R1 ADD
    {8'd3,  1'b1, 3'd4, 16'hFFFE, 1'b0, 4'd1},  // R1 SUB
    {8'd4,  1'b1, 3'd5, 16'h000D, 1'b0, 4'd1},  // R1 INC
    {8'd5,  1'b1, 3'd6, 16'h0004, 1'b0, 4'd1},  // R1 DEC
    {8'd6,  1'b1, 3'd7, 16'h0005, 1'b0, 4'd1},  // R1 AND
    {8'd7,  1'b1, 3'd7, 16'h000D, 1'b0, 4'd1},  // R1 OR
    {8'd8,  1'b1, 3'd7, 16'h000B, 1'b0, 4'd1},  // R1 XOR
    {8'd9,  1'b1, 3'd7, 16'hFFF8, 1'b0, 4'd1},  // R1 NOT
    {8'd10, 1'b1, 3'd7, 16'hFFFE, 1'b0, 4'd1},  // R1 pass A
    {8'd11, 1'b1, 3'd7, 16'h000C, 1'b0, 4'd1},  // R1 pass B
    {8'd12, 1'b1, 3'd7, 16'hFFFC, 1'b0, 4'd2},  // R2 SHL
    {8'd13, 1'b1, 3'd7, 16'h7FFF, 1'b0, 4'd2},  // R2 SHR zero in MSB
    {8'd14, 1'b1, 3'd5, 16'h0010, 1'b0, 4'd3},  // R3 ADI
    {8'd15, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd10}, // R10 BRN taken
    {8'd17, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd6},  // R6 BRZ not taken
    {8'd18, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd6},  // R6 BRN not taken
    {8'd19, 1'b1, 3'd6, 16'h0020, 1'b0, 4'd2},  // R2
    {8'd20, 1'b1, 3'd6, 16'h0040, 1'b0, 4'd2},  // R2
    {8'd21, 1'b1, 3'd4, 16'h0046, 1'b0, 4'd3},  // R3
    {8'd22, 1'b1, 3'd7, 16'd192,  1'b0, 4'd4},  // R4 old word
    {8'd23, 1'b1, 3'd5, 16'd80,   1'b0, 4'd1},  // R1
    {8'd24, 1'b1, 3'd1, 16'h0000, 1'b0, 4'd3},  // R3
    {8'd25, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd6},  // R6 BRZ +10
    {8'd35, 1'b0, 3'd0, 16'h0000, 1'b1, 4'd5},  // R5 store
    {8'd36, 1'b1, 3'd3, 16'd80,   1'b0, 4'd4},  // R4 new word
    {8'd37, 1'b1, 3'd6, 16'h0000, 1'b0, 4'd3},  // R3
    {8'd38, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd6},  // R6 BRZ +16
    {8'd54, 1'b1, 3'd1, 16'h0001, 1'b0, 4'd1},  // R1
    {8'd55, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd6},  // R6 BRZ -20
    {8'd35, 1'b0, 3'd0, 16'h0000, 1'b1, 4'd5},  // R5
    {8'd36, 1'b1, 3'd3, 16'd80,   1'b0, 4'd4},  // R4
    {8'd37, 1'b1, 3'd6, 16'h0000, 1'b0, 4'd3},  // R3
    {8'd38, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd6},  // R6 not taken
    {8'd39, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd7},  // R7 jump
    {8'd80, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd7},  // R7 target
    {8'd80, 1'b0, 3'd0, 16'h0000, 1'b0, 4'd6}   // R6 zero offset
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_valid = 1'b0;
  logic          load_ready;
  logic          load_sel = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [15:0]   load_data = '0;
  logic [AW-1:0] pc_o;
  logic          rf_we_o;
  logic [2:0]    rf_waddr_o;
  logic [15:0]   rf_wdata_o;
  logic          dm_we_o;
  logic [AW-1:0] dm_addr_o;
  logic [15:0]   dm_wdata_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sc_core #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_ready(load_ready),
    .load_sel(load_sel), .load_addr(load_addr), .load_data(load_data),
    .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
    .dm_wdata_o(dm_wdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns at the next falling edge
  task automatic load_word(input logic sel, input logic [AW-1:0] addr, input logic [15:0] data);
    load_valid = 1'b1;
    load_sel   = sel;
    load_addr  = addr;
    load_data  = data;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R8 pc in reset", 32'(pc_o), 32'd0);
    chk("R8 rf_we in reset", 32'(rf_we_o), 32'd0);
    chk("R8 dm_we in reset", 32'(dm_we_o), 32'd0);
    chk("R9 load_ready in reset", 32'(load_ready), 32'd1);

    for (int i = 0; i < NPROG; i++) load_word(1'b0, PROG[i][23:16], PROG[i][15:0]);
    load_word(1'b1, 8'd70, 16'd192);
    rst = 1'b0;

    for (int i = 0; i < NTRACE; i++) begin
      logic [32:0] t;
      string tg;
      t = TRACE[i];
      #1;
      tg = $sformatf("R%0d row %0d", t[3:0], i);
      chk({tg, " pc"}, 32'(pc_o), 32'(t[32:25]));
      chk({tg, " rf_we"}, 32'(rf_we_o), 32'(t[24]));
      if (t[24]) begin
        chk({tg, " waddr"}, 32'(rf_waddr_o), 32'(t[23:21]));
        chk({tg, " wdata"}, 32'(rf_wdata_o), 32'(t[20:5]));
      end
      chk({tg, " dm_we"}, 32'(dm_we_o), 32'(t[4]));
      if (t[4]) begin
        chk("R5 store addr", 32'(dm_addr_o), 32'd70);
        chk("R5 store data", 32'(dm_wdata_o), 32'd80);
      end
      @(negedge clk);
    end

    // reset mid-run
    rst = 1'b1;
    #1;
    chk("R8 rf_we gated", 32'(rf_we_o), 32'd0);
    chk("R8 dm_we gated", 32'(dm_we_o), 32'd0);
    @(negedge clk);
    #1;
    chk("R8 pc cleared", 32'(pc_o), 32'd0);
    chk("R9 ready in reset", 32'(load_ready), 32'd1);

    // second program
    load_word(1'b0, 8'd0, enc(OP_LDI, 3'd0, 3'd0, 3'd0));
    load_word(1'b0, 8'd1, enc(OP_LD,  3'd1, 3'd0, 3'd0));
    load_word(1'b0, 8'd2, enc(OP_SHR, 3'd2, 3'd0, 3'd1));
    load_word(1'b0, 8'd3, enc(OP_SHL, 3'd3, 3'd0, 3'd1));
    load_word(1'b0, 8'd4, enc(OP_ADI, 3'd4, 3'd0, 3'd7));
    load_word(1'b0, 8'd5, br(OP_BRZ, 3'd0, 6'b111111));
    load_word(1'b1, 8'd0, 16'hA5A5);
    rst = 1'b0;
    #1;
    chk("R3 LDI 0", 32'(rf_wdata_o), 32'd0);
    @(negedge clk); #1;
    chk("R9 dmem loaded via port", 32'(rf_wdata_o), 32'hA5A5);
    chk("R4 load dst", 32'(rf_waddr_o), 32'd1);
    @(negedge clk); #1;
    chk("R2 SHR pattern", 32'(rf_wdata_o), 32'h52D2);
    @(negedge clk); #1;
    chk("R2 SHL drops MSB", 32'(rf_wdata_o), 32'h4B4A);
    @(negedge clk); #1;
    chk("R3 ADI max operand", 32'(rf_wdata_o), 32'd7);
    @(negedge clk); #1;
    chk("R10 branch no write", 32'(rf_we_o), 32'd0);
    chk("R9 not ready running", 32'(load_ready), 32'd0);
    @(negedge clk); #1;
    chk("R6 offset -1", 32'(pc_o), 32'd4);
    load_valid = 1'b1;
    load_sel   = 1'b0;
    load_addr  = 8'd4;
    load_data  = enc(OP_LDI, 3'd5, 3'd0, 3'd1);
    @(negedge clk);
    load_valid = 1'b0;
    #1;
    chk("R6 loop pc", 32'(pc_o), 32'd5);
    @(negedge clk); #1;
    chk("R9 ignored load waddr", 32'(rf_waddr_o), 32'd4);
    chk("R9 ignored load wdata", 32'(rf_wdata_o), 32'd7);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule